// File: doc/BRIEF.md
# Serial Memory Power-Up Identification Sequencer

This block brings an external serial NOR flash or pseudo-static RAM device into a known state after reset, before any memory-mapped traffic is allowed. It runs by itself once reset is released. If quad instruction mode is enabled, it first sends a quad-mode exit opcode so the device is known to be in single-line mode. It then issues the two-instruction software reset and holds the bus idle for a programmable number of microseconds. Next it reads three identification bytes and compares them with the configured manufacturer, device type and density values. Quad instruction mode is entered only when it is enabled and the identification matched. The block then raises its completion flag.

The block does not shift bits. It hands bytes, one at a time, to a serial shifter over a request/acknowledge interface. Each byte carries its lane mode (single or quad), a read flag and an end-of-instruction flag. The shifter releases chip-select after a byte marked as the end of an instruction. All idle times are given in nanoseconds or microseconds and are converted to clock cycles with the parameter `CLK_MHZ`.

The density setting is a 16-bit word. Its low byte is the expected density, and its high byte is a mask applied to the returned density byte before the compare. This lets bits of the returned byte that carry no meaning be excluded.

Top module: `spi_mem_bringup`

## Requirements
- R1: The instruction order is fixed:
  - an optional quad exit (only when `cfg_qpi_en`=1);
  - reset-enable 0x66;
  - reset 0x99;
  - identification read, which is opcode 0x9F followed by three read bytes (rd=1, tx=0x00), the last of them marked last;
  - an optional quad entry;
  - then completion.
  Every single-byte instruction is marked last.
- R2: While `byte_req` is high and `byte_ack` is low, the request and all byte fields hold steady. After a non-last byte is acknowledged, the next byte of the same instruction is requested in the very next cycle.
- R3: After a last byte is acknowledged, `byte_req` stays low for exactly N cycles before the next instruction, where N = max(1, ceil(`cfg_cs_gap_ns`·CLK_MHZ/1000)). The identification-read instruction is followed by this N.
- R4: After the reset opcode 0x99, the low time is max(N, max(1, `cfg_rst_wait_us`·CLK_MHZ)) cycles.
- R5: If the opcode of an instruction is one of 0x06, 0x20, 0x52, 0xD8, 0x60, 0xC7, 0x75, 0xB0, 0x7A, 0x30 and `cfg_is_ram`=0, the low time after it is max(N, max(1, ceil(`cfg_cs_long_gap_ns`·CLK_MHZ/1000))). When `cfg_is_ram`=1, the long setting is ignored and N applies.
- R6: The read bytes arrive in the order manufacturer, type, density. The identification matches when the manufacturer equals `cfg_mfr_id`, the type equals `cfg_dev_type`, and (density AND `cfg_density[15:8]`) equals `cfg_density[7:0]`. After the read, exactly one of `id_match` and `id_error` is set.
- R7: On a mismatch in any field, `id_error` is set and the quad entry is skipped, even when it is enabled. `qpi_mode` stays 0.
- R8: The quad exit opcode `cfg_qpi_exit_op` is sent with `byte_quad`=1. The quad entry opcode `cfg_qpi_enter_op` is sent with `byte_quad`=0. `qpi_mode` becomes 1 once the entry byte is acknowledged.
- R9: `seq_done` rises after the final idle time has elapsed, in the cycle where the next instruction would otherwise start. It then stays high, with `byte_req` low.
- R10: During reset, `byte_req`, `seq_done`, `id_match`, `id_error` and `qpi_mode` are 0. The first byte request appears in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_is_ram | input | 1 | Device is pseudo-static RAM (long idle ignored) |
| cfg_qpi_en | input | 1 | Enable quad-mode exit at start and entry at end |
| cfg_mfr_id | input | 8 | Expected manufacturer byte |
| cfg_dev_type | input | 8 | Expected device type byte |
| cfg_density | input | 16 | [15:8] mask, [7:0] expected density |
| cfg_rst_wait_us | input | US_W | Wait after software reset, microseconds |
| cfg_cs_gap_ns | input | NS_W | Minimum chip-select idle between instructions, ns |
| cfg_cs_long_gap_ns | input | NS_W | Idle after write-enable/erase-class opcodes, ns |
| cfg_qpi_enter_op | input | 8 | Quad entry opcode |
| cfg_qpi_exit_op | input | 8 | Quad exit opcode |
| byte_req | output | 1 | Byte request to shifter |
| byte_tx | output | 8 | Byte to transmit |
| byte_quad | output | 1 | Byte uses the quad bus |
| byte_rd | output | 1 | Byte is a read (shifter returns byte_rx) |
| byte_last | output | 1 | Release chip-select after this byte |
| byte_ack | input | 1 | Shifter finished the current byte |
| byte_rx | input | 8 | Received byte, valid with byte_ack on reads |
| qpi_mode | output | 1 | Device is in quad instruction mode |
| id_match | output | 1 | Identification matched |
| id_error | output | 1 | Identification mismatched |
| seq_done | output | 1 | Bring-up sequence complete |

## Verification
Byte fields are due in the cycle after the acknowledge of the previous non-last byte, with no intervening register. After a last byte, the bench samples each clock and counts the low cycles of `byte_req`. It requires the next request on exactly the (N+1)th sample after the acknowledge, with N taken from R3, R4 or R5. `seq_done` is expected at the sample right after the final low run, and the match/error flags one cycle after the acknowledge of the third read byte. The reference model runs on the falling edge, builds the expected byte list from the configuration and from the device bytes it supplies, and compares every field, every gap length and the done flag on every clock.

// File: rtl/memid_pkg.sv
package memid_pkg;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_BYTE,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        STEP_QEXIT,
        STEP_RSTEN,
        STEP_RST,
        STEP_RDID,
        STEP_QENTER,
        STEP_FIN
    } seq_step_e;

    typedef struct packed {
        logic [7:0] tx;
        logic       quad;
        logic       rd;
        logic       last;
    } byte_op_t;

    localparam logic [7:0] OP_RESET_ENABLE = 8'h66;
    localparam logic [7:0] OP_RESET        = 8'h99;
    localparam logic [7:0] OP_READ_ID      = 8'h9F;
    localparam int         ID_BYTES        = 3;

    function automatic logic [31:0] ns_to_cycles(input logic [31:0] ns, input logic [31:0] mhz);
        logic [31:0] prod;
        prod = (ns * mhz + 32'd999) / 32'd1000;
        if (prod == 32'd0) prod = 32'd1;
        return prod;
    endfunction

    function automatic logic [31:0] us_to_cycles(input logic [31:0] us, input logic [31:0] mhz);
        logic [31:0] prod;
        prod = us * mhz;
        if (prod == 32'd0) prod = 32'd1;
        return prod;
    endfunction

    function automatic logic needs_long_idle(input logic [7:0] op);
        case (op)
            8'h06, 8'h20, 8'h52, 8'hD8, 8'h60,
            8'hC7, 8'h75, 8'hB0, 8'h7A, 8'h30: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/memid_timing.sv
module memid_timing #(
    parameter int CLK_MHZ = 200,
    parameter int US_W    = 16,
    parameter int NS_W    = 16,
    parameter int CNT_W   = 32
) (
    input  logic [US_W-1:0]  rst_wait_us,
    input  logic [NS_W-1:0]  gap_ns,
    input  logic [NS_W-1:0]  long_gap_ns,
    output logic [CNT_W-1:0] gap_cyc,
    output logic [CNT_W-1:0] long_cyc,
    output logic [CNT_W-1:0] wait_cyc
);
    localparam logic [31:0] MHZ = 32'(CLK_MHZ);

    always_comb begin
        gap_cyc  = CNT_W'(memid_pkg::ns_to_cycles(32'(gap_ns), MHZ));
        long_cyc = CNT_W'(memid_pkg::ns_to_cycles(32'(long_gap_ns), MHZ));
        wait_cyc = CNT_W'(memid_pkg::us_to_cycles(32'(rst_wait_us), MHZ));
    end
endmodule

// File: rtl/memid_gap_timer.sv
module memid_gap_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cycles,
    output logic             expired
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_cycles - CNT_W'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign expired = (remain_q == '0);
endmodule

// File: rtl/memid_id_check.sv
module memid_id_check (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_en,
    input  logic [1:0]  cap_idx,
    input  logic [7:0]  rx_byte,
    input  logic [7:0]  exp_mfr,
    input  logic [7:0]  exp_type,
    input  logic [15:0] exp_density,
    output logic        match_now
);
    localparam int HELD = memid_pkg::ID_BYTES - 1;

    logic [7:0] held_q [HELD];

    for (genvar g = 0; g < HELD; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q[g] <= '0;
            end else if (cap_en && (cap_idx == 2'(g))) begin
                held_q[g] <= rx_byte;
            end
        end
    end

    logic mfr_ok, type_ok, dens_ok;
    always_comb begin
        mfr_ok    = (held_q[0] == exp_mfr);
        type_ok   = (held_q[1] == exp_type);
        dens_ok   = ((rx_byte & exp_density[15:8]) == exp_density[7:0]);
        match_now = mfr_ok && type_ok && dens_ok;
    end
endmodule

// File: rtl/spi_mem_bringup.sv
module spi_mem_bringup #(
    parameter int CLK_MHZ = 200,
    parameter int US_W    = 16,
    parameter int NS_W    = 16,
    parameter int CNT_W   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_is_ram,
    input  logic            cfg_qpi_en,
    input  logic [7:0]      cfg_mfr_id,
    input  logic [7:0]      cfg_dev_type,
    input  logic [15:0]     cfg_density,
    input  logic [US_W-1:0] cfg_rst_wait_us,
    input  logic [NS_W-1:0] cfg_cs_gap_ns,
    input  logic [NS_W-1:0] cfg_cs_long_gap_ns,
    input  logic [7:0]      cfg_qpi_enter_op,
    input  logic [7:0]      cfg_qpi_exit_op,
    output logic            byte_req,
    output logic [7:0]      byte_tx,
    output logic            byte_quad,
    output logic            byte_rd,
    output logic            byte_last,
    input  logic            byte_ack,
    input  logic [7:0]      byte_rx,
    output logic            qpi_mode,
    output logic            id_match,
    output logic            id_error,
    output logic            seq_done
);
    import memid_pkg::*;

    localparam logic [1:0] RDID_LAST = 2'(ID_BYTES);

    seq_state_e state_q;
    seq_step_e  step_q, step_nx;
    logic [1:0] bidx_q;
    logic       qpi_q, match_q, error_q;

    logic [CNT_W-1:0] gap_cyc, long_cyc, wait_cyc, gap_sel;
    logic             tmr_load, tmr_expired;
    logic             id_cap, id_match_now;
    logic             accept;
    logic [7:0]       op_first;
    byte_op_t         cur;

    memid_timing #(
        .CLK_MHZ(CLK_MHZ), .US_W(US_W), .NS_W(NS_W), .CNT_W(CNT_W)
    ) u_timing (
        .rst_wait_us (cfg_rst_wait_us),
        .gap_ns      (cfg_cs_gap_ns),
        .long_gap_ns (cfg_cs_long_gap_ns),
        .gap_cyc     (gap_cyc),
        .long_cyc    (long_cyc),
        .wait_cyc    (wait_cyc)
    );

    memid_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .load        (tmr_load),
        .load_cycles (gap_sel),
        .expired     (tmr_expired)
    );

    memid_id_check u_idchk (
        .clk         (clk),
        .rst         (rst),
        .cap_en      (id_cap),
        .cap_idx     (bidx_q - 2'd1),
        .rx_byte     (byte_rx),
        .exp_mfr     (cfg_mfr_id),
        .exp_type    (cfg_dev_type),
        .exp_density (cfg_density),
        .match_now   (id_match_now)
    );

    // Opcode of the instruction in progress
    always_comb begin
        case (step_q)
            STEP_QEXIT:  op_first = cfg_qpi_exit_op;
            STEP_RSTEN:  op_first = OP_RESET_ENABLE;
            STEP_RST:    op_first = OP_RESET;
            STEP_RDID:   op_first = OP_READ_ID;
            STEP_QENTER: op_first = cfg_qpi_enter_op;
            default:     op_first = 8'h00;
        endcase
    end

    // Byte presented to the shifter
    always_comb begin
        cur.tx   = (bidx_q == 2'd0) ? op_first : 8'h00;
        cur.rd   = (step_q == STEP_RDID) && (bidx_q != 2'd0);
        cur.last = (step_q == STEP_RDID) ? (bidx_q == RDID_LAST) : 1'b1;
        cur.quad = (step_q == STEP_QEXIT) || qpi_q;
    end

    // Chip-select idle length after the current instruction
    always_comb begin
        gap_sel = gap_cyc;
        if (needs_long_idle(op_first) && !cfg_is_ram && (long_cyc > gap_sel)) begin
            gap_sel = long_cyc;
        end
        if ((step_q == STEP_RST) && (wait_cyc > gap_sel)) begin
            gap_sel = wait_cyc;
        end
    end

    always_comb begin
        case (step_q)
            STEP_QEXIT:  step_nx = STEP_RSTEN;
            STEP_RSTEN:  step_nx = STEP_RST;
            STEP_RST:    step_nx = STEP_RDID;
            STEP_RDID:   step_nx = (cfg_qpi_en && id_match_now) ? STEP_QENTER : STEP_FIN;
            default:     step_nx = STEP_FIN;
        endcase
    end

    assign accept   = (state_q == ST_BYTE) && byte_ack;
    assign tmr_load = accept && cur.last;
    assign id_cap   = accept && cur.rd && !cur.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            step_q  <= STEP_RSTEN;
            bidx_q  <= '0;
            qpi_q   <= 1'b0;
            match_q <= 1'b0;
            error_q <= 1'b0;
        end else begin
            case (state_q)
                ST_BOOT: begin
                    step_q  <= cfg_qpi_en ? STEP_QEXIT : STEP_RSTEN;
                    state_q <= ST_BYTE;
                end
                ST_BYTE: begin
                    if (byte_ack) begin
                        if (cur.last) begin
                            step_q  <= step_nx;
                            state_q <= ST_GAP;
                            bidx_q  <= '0;
                        end else begin
                            bidx_q <= bidx_q + 2'd1;
                        end
                        if (step_q == STEP_QENTER) qpi_q <= 1'b1;
                        if (step_q == STEP_QEXIT)  qpi_q <= 1'b0;
                        if (cur.rd && cur.last) begin
                            match_q <= id_match_now;
                            error_q <= !id_match_now;
                        end
                    end
                end
                ST_GAP: begin
                    if (tmr_expired) begin
                        state_q <= (step_q == STEP_FIN) ? ST_DONE : ST_BYTE;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    assign byte_req  = (state_q == ST_BYTE);
    assign byte_tx   = cur.tx;
    assign byte_quad = cur.quad;
    assign byte_rd   = cur.rd;
    assign byte_last = cur.last;
    assign qpi_mode  = qpi_q;
    assign id_match  = match_q;
    assign id_error  = error_q;
    assign seq_done  = (state_q == ST_DONE);
endmodule

// File: rtl/spi_mem_bringup_sva.sv
module spi_mem_bringup_sva #(
    parameter int CLK_MHZ = 200,
    parameter int NS_W    = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [NS_W-1:0] cfg_cs_gap_ns,
    input logic            byte_req,
    input logic [7:0]      byte_tx,
    input logic            byte_quad,
    input logic            byte_rd,
    input logic            byte_last,
    input logic            byte_ack,
    input logic            qpi_mode,
    input logic            id_match,
    input logic            id_error,
    input logic            seq_done
);
    logic        idle_q;
    logic [31:0] idle_cnt_q;
    logic [31:0] min_gap;

    assign min_gap = memid_pkg::ns_to_cycles(32'(cfg_cs_gap_ns), 32'(CLK_MHZ));

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q     <= 1'b0;
            idle_cnt_q <= '0;
        end else if (byte_req && byte_ack && byte_last) begin
            idle_q     <= 1'b1;
            idle_cnt_q <= '0;
        end else if (byte_req) begin
            idle_q <= 1'b0;
        end else if (idle_q) begin
            idle_cnt_q <= idle_cnt_q + 32'd1;
        end
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (byte_req && !byte_ack) |=> (byte_req && $stable(byte_tx) && $stable(byte_quad)
                                     && $stable(byte_rd) && $stable(byte_last)));

    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_req && byte_ack && byte_last) |=> !byte_req);

    assert_min_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_req && idle_q) |-> (idle_cnt_q >= min_gap));

    assert_flags_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({id_match, id_error}));

    assert_quad_entry_single_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(qpi_mode) |-> $past(byte_req && byte_ack && !byte_quad));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> (seq_done && !byte_req));

    assert_skip_on_error_R7: assert property (@(posedge clk) disable iff (rst)
        id_error |-> !qpi_mode);
endmodule

bind spi_mem_bringup spi_mem_bringup_sva #(.CLK_MHZ(CLK_MHZ), .NS_W(NS_W)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .cfg_cs_gap_ns (cfg_cs_gap_ns),
    .byte_req      (byte_req),
    .byte_tx       (byte_tx),
    .byte_quad     (byte_quad),
    .byte_rd       (byte_rd),
    .byte_last     (byte_last),
    .byte_ack      (byte_ack),
    .qpi_mode      (qpi_mode),
    .id_match      (id_match),
    .id_error      (id_error),
    .seq_done      (seq_done)
);

// File: tb/tb_spi_mem_bringup.sv
`timescale 1ns/1ps
module tb_spi_mem_bringup;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_is_ram = 1'b0, cfg_qpi_en = 1'b0;
    logic [7:0]  cfg_mfr_id = 8'hC2, cfg_dev_type = 8'h25;
    logic [15:0] cfg_density = 16'hFF17;
    logic [15:0] cfg_rst_wait_us = 16'd1;
    logic [15:0] cfg_cs_gap_ns = 16'd30, cfg_cs_long_gap_ns = 16'd100;
    logic [7:0]  cfg_qpi_enter_op = 8'h35, cfg_qpi_exit_op = 8'hF5;
    logic        byte_req, byte_quad, byte_rd, byte_last;
    logic [7:0]  byte_tx;
    logic        byte_ack = 1'b0;
    logic [7:0]  byte_rx = 8'h00;
    logic        qpi_mode, id_match, id_error, seq_done;

    always #2.5 clk = ~clk;

    spi_mem_bringup dut (
        .clk(clk), .rst(rst), .cfg_is_ram(cfg_is_ram), .cfg_qpi_en(cfg_qpi_en),
        .cfg_mfr_id(cfg_mfr_id), .cfg_dev_type(cfg_dev_type), .cfg_density(cfg_density),
        .cfg_rst_wait_us(cfg_rst_wait_us), .cfg_cs_gap_ns(cfg_cs_gap_ns),
        .cfg_cs_long_gap_ns(cfg_cs_long_gap_ns), .cfg_qpi_enter_op(cfg_qpi_enter_op),
        .cfg_qpi_exit_op(cfg_qpi_exit_op), .byte_req(byte_req), .byte_tx(byte_tx),
        .byte_quad(byte_quad), .byte_rd(byte_rd), .byte_last(byte_last),
        .byte_ack(byte_ack), .byte_rx(byte_rx), .qpi_mode(qpi_mode),
        .id_match(id_match), .id_error(id_error), .seq_done(seq_done)
    );

    int compared = 0;
    int mismatched = 0;

    logic [7:0] dev_id [3];
    logic [7:0] q_tx [$];
    logic       q_quad [$], q_rd [$], q_last [$];
    int         q_gap [$];
    string      q_tag [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ns_cyc(input int ns);
        int c = (ns * 200 + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int us_cyc(input int us);
        int c = us * 200;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic bit long_class(input logic [7:0] op);
        return op inside {8'h06, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7, 8'h75, 8'hB0, 8'h7A, 8'h30};
    endfunction

    function automatic int gap_for(input logic [7:0] op);
        int g = ns_cyc(int'(cfg_cs_gap_ns));
        int l = ns_cyc(int'(cfg_cs_long_gap_ns));
        if (long_class(op) && !cfg_is_ram && l > g) return l;
        return g;
    endfunction

    task automatic push(input logic [7:0] tx, input logic qd, input logic rd,
                        input logic last, input int gap, input string tag);
        q_tx.push_back(tx); q_quad.push_back(qd); q_rd.push_back(rd);
        q_last.push_back(last); q_gap.push_back(gap); q_tag.push_back(tag);
    endtask

    bit exp_match;

    task automatic build_expect();
        int w;
        q_tx.delete(); q_quad.delete(); q_rd.delete();
        q_last.delete(); q_gap.delete(); q_tag.delete();
        exp_match = (dev_id[0] == cfg_mfr_id) && (dev_id[1] == cfg_dev_type) &&
                    ((dev_id[2] & cfg_density[15:8]) == cfg_density[7:0]);
        if (cfg_qpi_en) push(cfg_qpi_exit_op, 1'b1, 1'b0, 1'b1, gap_for(cfg_qpi_exit_op), "R5");
        push(8'h66, 1'b0, 1'b0, 1'b1, gap_for(8'h66), "R3");
        w = us_cyc(int'(cfg_rst_wait_us));
        push(8'h99, 1'b0, 1'b0, 1'b1, (w > gap_for(8'h99)) ? w : gap_for(8'h99), "R4");
        push(8'h9F, 1'b0, 1'b0, 1'b0, 0, "R2");
        push(8'h00, 1'b0, 1'b1, 1'b0, 0, "R2");
        push(8'h00, 1'b0, 1'b1, 1'b0, 0, "R2");
        push(8'h00, 1'b0, 1'b1, 1'b1, gap_for(8'h9F), "R3");
        if (cfg_qpi_en && exp_match)
            push(cfg_qpi_enter_op, 1'b0, 1'b0, 1'b1, gap_for(cfg_qpi_enter_op), "R5");
    endtask

    // One complete bring-up, compared every clock against the behavioural model
    task automatic run_seq(input int lat, input string name);
        bit in_gap = 1'b1, fin = 1'b0;
        int gcnt = 0, gexp = 0, hold = 0, post = 0, rdn = 0, guard = 0;
        string gtag = "R10";
        build_expect();
        byte_ack = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 req in reset", 32'(byte_req), 0);
        chk("R10 done in reset", 32'(seq_done), 0);
        chk("R10 flags in reset", {29'd0, id_match, id_error, qpi_mode}, 0);
        rst = 1'b0;
        while (1) begin
            @(negedge clk);
            byte_ack = 1'b0;
            guard++;
            if (guard > 20000) begin
                mismatched++;
                $display("FAIL R9: watchdog in %s, actual running expected done", name);
                break;
            end
            if (fin) begin
                chk("R9 done held", 32'(seq_done), 1);
                chk("R9 req low after done", 32'(byte_req), 0);
                post++;
                if (post == 3) break;
                continue;
            end
            chk("R9 done early", 32'(seq_done), 0);
            if (in_gap) begin
                if (byte_req) begin
                    chk({gtag, " idle length"}, gcnt, gexp);
                    in_gap = 1'b0;
                    hold = 0;
                end else begin
                    gcnt++;
                    if (q_tx.size() == 0 && gcnt == gexp) fin = 1'b1;
                    continue;
                end
            end
            if (!byte_req) begin
                chk("R2 request dropped", 32'(byte_req), 1);
                continue;
            end
            if (q_tx.size() == 0) begin
                chk("R1 extra byte", 32'(byte_tx), 32'hFFFF);
                continue;
            end
            chk("R1 tx", 32'(byte_tx), 32'(q_tx[0]));
            chk("R8 lane", 32'(byte_quad), 32'(q_quad[0]));
            chk("R1 rd", 32'(byte_rd), 32'(q_rd[0]));
            chk("R1 last", 32'(byte_last), 32'(q_last[0]));
            hold++;
            if (hold == lat) begin
                byte_ack = 1'b1;
                byte_rx = q_rd[0] ? dev_id[rdn] : 8'h5A;
                if (q_rd[0]) rdn++;
                if (q_last[0]) begin
                    in_gap = 1'b1; gcnt = 0; gexp = q_gap[0]; gtag = q_tag[0];
                end
                hold = 0;
                void'(q_tx.pop_front()); void'(q_quad.pop_front()); void'(q_rd.pop_front());
                void'(q_last.pop_front()); void'(q_gap.pop_front()); void'(q_tag.pop_front());
            end
        end
        chk("R6 id_match", 32'(id_match), 32'(exp_match));
        chk("R6 id_error", 32'(id_error), 32'(!exp_match));
        chk("R8 R7 qpi_mode", 32'(qpi_mode), 32'(cfg_qpi_en && exp_match));
    endtask

    initial begin
        // T1: NOR, no quad, matching identity
        dev_id = '{8'hC2, 8'h25, 8'h17};
        run_seq(1, "nor_plain");
        // T2: RAM with quad mode, slower shifter
        cfg_is_ram = 1'b1; cfg_qpi_en = 1'b1;
        run_seq(2, "ram_quad");
        // T3: density mask hides upper bits (R6)
        cfg_is_ram = 1'b0; cfg_density = 16'h3F17;
        dev_id = '{8'hC2, 8'h25, 8'hD7};
        run_seq(1, "mask_ok");
        // T4: unmasked density bit differs -> error, quad skipped (R7)
        dev_id = '{8'hC2, 8'h25, 8'h16};
        run_seq(1, "dens_bad");
        // T5: manufacturer mismatch (R7)
        cfg_density = 16'hFF17;
        dev_id = '{8'hC3, 8'h25, 8'h17};
        run_seq(2, "mfr_bad");
        // T6: type mismatch
        dev_id = '{8'hC2, 8'h24, 8'h17};
        run_seq(1, "type_bad");
        // T7: long-idle opcodes on NOR (R5)
        dev_id = '{8'hC2, 8'h25, 8'h17};
        cfg_qpi_enter_op = 8'h06; cfg_qpi_exit_op = 8'h30;
        run_seq(3, "long_nor");
        // T8: same opcodes on RAM: long setting ignored (R5)
        cfg_is_ram = 1'b1;
        run_seq(1, "long_ram");
        // T9: zero reset wait -> short idle dominates (R4)
        cfg_is_ram = 1'b0; cfg_qpi_en = 1'b0; cfg_rst_wait_us = 16'd0;
        cfg_cs_gap_ns = 16'd1;
        run_seq(1, "min_wait");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule